// File: doc/BRIEF.md
# Two-Level Interrupt Flag Aggregator

This block collects interrupt events from several peripherals and presents them to a small microcontroller core as one pending flag per interrupt vector. Each vector owns a bank of module flags with per-bit enables. A peripheral raises a module flag with a single-cycle event pulse. The vector's CPU-level pending flag is edge-set: an event on an enabled module bit sets it, and it is cleared when the core takes the vector.

The block never re-arms a vector on its own. Software must clear module flags one at a time. On every such clear, the block checks whether an enabled module flag is still set, and if so it sets the CPU-level flag again. Each vector then raises a new request until the bank is empty. A per-vector enable masks the CPU flag onto the request outputs.

A register port gives access to all flags and enables, and its read data is registered. A vector-acknowledge input clears the pending flag of the vector it names.

Top module: `irq_flag_agg`

## Requirements
- R1: After reset, all module flags, module enables, CPU pending flags, vector enables and request outputs are 0. The CPU flag register reads 0x05.
- R2: A module event pulse sets its module flag bit, which then holds. Writing 0 to a module flag bit clears it, and writing 1 has no effect.
- R3: When a module event and a software clear hit the same module flag bit in one cycle, the bit ends up set.
- R4: An event on a module bit whose module enable is 1 sets the vector's CPU pending flag at the next clock edge. An event on a disabled bit sets only the module flag.
- R5: An acknowledge with index v clears only vector v's CPU pending flag, and leaves all module flags unchanged.
- R6: When a set event for vector v and an acknowledge of vector v arrive in the same cycle, the CPU pending flag of v ends up set.
- R7: When software clears a set module flag of vector v, the CPU flag of v is set again if an enabled module flag of v is still set. If none is, the CPU flag is left alone.
- R8: In the CPU flag register (address 0), vector v's pending flag sits at bit 2v+1, and software can write it to 0 or 1. Bits 0 and 2 always read 1, and bits 4 and 6 always read 0, whatever is written.
- R9: The request output irq[v] equals the CPU pending flag of v ANDed with vector enable bit v. A write to the vector enables shows on irq right after the clock edge that takes the write.
- R10: The register map is: address 0 holds the CPU flags, address 1 holds the vector enables in bits v, address 2+2v holds the module flags of vector v, and address 3+2v holds the module enables of vector v. reg_rdata holds, one edge after reg_addr is presented, the register content at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_evt | input | NUM_VEC*MOD_W | Single-cycle module event pulses; the slice for vector v is [v*MOD_W +: MOD_W] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| ack_valid | input | 1 | The core takes a vector this cycle |
| ack_vec | input | VEC_W | Index of the vector being taken |
| irq | output | NUM_VEC | Per-vector interrupt requests |

## Verification
Some checks claim that a flag is cleared or unchanged. These assume no register write happens in that cycle, because a software write or a clear-driven re-arm would legitimately override the outcome. The stimulus keeps writes, event pulses and acknowledges in separate cycles, except in the two deliberate collision scenarios. Each of those combines exactly one event with exactly one clear or acknowledge of the same target. The checks also assume ack_vec names an existing vector, and the bench only acknowledges vectors 0 to 2.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADR_CPU_FLAGS = 0;
  localparam int unsigned ADR_VEC_EN    = 1;

  // Position of vector v's pending flag inside the CPU flag register.
  function automatic int unsigned pend_pos(input int unsigned v);
    return 2 * v + 1;
  endfunction

  function automatic int unsigned mflag_adr(input int unsigned v);
    return 2 + 2 * v;
  endfunction

  function automatic int unsigned men_adr(input int unsigned v);
    return 3 + 2 * v;
  endfunction
endpackage

// File: rtl/irq_mod_bank.sv
module irq_mod_bank #(
  parameter int MOD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MOD_W-1:0] evt,
  input  logic             wr_flag,
  input  logic             wr_en,
  input  logic [MOD_W-1:0] wdata,
  output logic [MOD_W-1:0] flag_q,
  output logic [MOD_W-1:0] en_q,
  output logic             set_req
);
  logic [MOD_W-1:0] clr_mask;
  logic [MOD_W-1:0] flag_d;
  logic             clear_hit;

  always_comb begin
    clr_mask  = wr_flag ? ~wdata : '0;
    // Event beats a same-cycle clear on the same bit.
    flag_d    = (flag_q & ~clr_mask) | evt;
    clear_hit = |(flag_q & clr_mask);
    set_req   = (|(evt & en_q)) | (clear_hit & (|(flag_d & en_q)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      if (wr_en) en_q <= wdata;
    end
  end
endmodule

// File: rtl/irq_cpu_flags.sv
module irq_cpu_flags #(
  parameter int NUM_VEC = 4,
  parameter int VEC_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VEC-1:0] set_req,
  input  logic               ack_valid,
  input  logic [VEC_W-1:0]   ack_vec,
  input  logic               sw_we,
  input  logic [NUM_VEC-1:0] sw_val,
  input  logic               ven_we,
  input  logic [NUM_VEC-1:0] ven_val,
  output logic [NUM_VEC-1:0] flag_q,
  output logic [NUM_VEC-1:0] ven_q,
  output logic [NUM_VEC-1:0] irq_q
);
  logic [NUM_VEC-1:0] flag_d;
  logic [NUM_VEC-1:0] ven_d;

  always_comb begin
    ven_d = ven_we ? ven_val : ven_q;
    for (int v = 0; v < NUM_VEC; v++) begin
      flag_d[v] = flag_q[v];
      if (sw_we) flag_d[v] = sw_val[v];
      if (ack_valid && ack_vec == VEC_W'(v)) flag_d[v] = 1'b0;
      if (set_req[v]) flag_d[v] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      ven_q  <= '0;
      irq_q  <= '0;
    end else begin
      flag_q <= flag_d;
      ven_q  <= ven_d;
      irq_q  <= flag_d & ven_d;
    end
  end
endmodule

// File: rtl/irq_reg_read.sv
module irq_reg_read #(
  parameter int NUM_VEC = 4,
  parameter int MOD_W   = 8,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        cpu_img,
  input  logic [NUM_VEC-1:0]       ven_q,
  input  logic [NUM_VEC*MOD_W-1:0] mflag,
  input  logic [NUM_VEC*MOD_W-1:0] men,
  output logic [DATA_W-1:0]        rdata
);
  import irq_agg_pkg::*;
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (addr == ADDR_W'(ADR_CPU_FLAGS)) rd_d = cpu_img;
    if (addr == ADDR_W'(ADR_VEC_EN))    rd_d = DATA_W'(ven_q);
    for (int v = 0; v < NUM_VEC; v++) begin
      if (addr == ADDR_W'(mflag_adr(v))) rd_d = DATA_W'(mflag[v*MOD_W +: MOD_W]);
      if (addr == ADDR_W'(men_adr(v)))   rd_d = DATA_W'(men[v*MOD_W +: MOD_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end
endmodule

// File: rtl/irq_flag_agg.sv
module irq_flag_agg #(
  parameter int NUM_VEC  = 4,
  parameter int MOD_W    = 8,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int RSV_ONES = 2,
  localparam int VEC_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_VEC*MOD_W-1:0] mod_evt,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  input  logic                     ack_valid,
  input  logic [VEC_W-1:0]         ack_vec,
  output logic [NUM_VEC-1:0]       irq
);
  import irq_agg_pkg::*;

  logic [NUM_VEC*MOD_W-1:0] mod_flag_flat;
  logic [NUM_VEC*MOD_W-1:0] mod_en_flat;
  logic [NUM_VEC-1:0]       set_req;
  logic [NUM_VEC-1:0]       cpu_flag_q;
  logic [NUM_VEC-1:0]       ven_q;
  logic [NUM_VEC-1:0]       sw_val;
  logic [DATA_W-1:0]        cpu_img;
  logic                     cpu_we;
  logic                     ven_we;

  assign cpu_we = reg_we && (reg_addr == ADDR_W'(ADR_CPU_FLAGS));
  assign ven_we = reg_we && (reg_addr == ADDR_W'(ADR_VEC_EN));

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_bank
    logic wr_flag, wr_en;
    assign wr_flag   = reg_we && (reg_addr == ADDR_W'(mflag_adr(v)));
    assign wr_en     = reg_we && (reg_addr == ADDR_W'(men_adr(v)));
    assign sw_val[v] = reg_wdata[pend_pos(v)];

    irq_mod_bank #(.MOD_W(MOD_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .evt     (mod_evt[v*MOD_W +: MOD_W]),
      .wr_flag (wr_flag),
      .wr_en   (wr_en),
      .wdata   (reg_wdata[MOD_W-1:0]),
      .flag_q  (mod_flag_flat[v*MOD_W +: MOD_W]),
      .en_q    (mod_en_flat[v*MOD_W +: MOD_W]),
      .set_req (set_req[v])
    );
  end

  // CPU flag image: odd bits carry pending flags, low even bits are fixed 1.
  for (genvar b = 0; b < DATA_W; b++) begin : g_img
    if ((b % 2 == 1) && ((b - 1) / 2 < NUM_VEC)) begin : g_pend
      assign cpu_img[b] = cpu_flag_q[(b - 1) / 2];
    end else if ((b % 2 == 0) && (b / 2 < RSV_ONES)) begin : g_one
      assign cpu_img[b] = 1'b1;
    end else begin : g_zero
      assign cpu_img[b] = 1'b0;
    end
  end

  irq_cpu_flags #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_cpu (
    .clk       (clk),
    .rst       (rst),
    .set_req   (set_req),
    .ack_valid (ack_valid),
    .ack_vec   (ack_vec),
    .sw_we     (cpu_we),
    .sw_val    (sw_val),
    .ven_we    (ven_we),
    .ven_val   (reg_wdata[NUM_VEC-1:0]),
    .flag_q    (cpu_flag_q),
    .ven_q     (ven_q),
    .irq_q     (irq)
  );

  irq_reg_read #(.NUM_VEC(NUM_VEC), .MOD_W(MOD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .addr    (reg_addr),
    .cpu_img (cpu_img),
    .ven_q   (ven_q),
    .mflag   (mod_flag_flat),
    .men     (mod_en_flat),
    .rdata   (reg_rdata)
  );
endmodule

// File: rtl/irq_flag_agg_chk.sv
module irq_flag_agg_chk #(
  parameter int NUM_VEC  = 4,
  parameter int MOD_W    = 8,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int RSV_ONES = 2,
  parameter int VEC_W    = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_VEC*MOD_W-1:0] mod_evt,
  input logic                     reg_we,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [DATA_W-1:0]        reg_rdata,
  input logic                     ack_valid,
  input logic [VEC_W-1:0]         ack_vec,
  input logic [NUM_VEC-1:0]       irq,
  input logic [NUM_VEC-1:0]       cpu_flag_q,
  input logic [NUM_VEC-1:0]       ven_q,
  input logic [NUM_VEC*MOD_W-1:0] mod_flag_flat,
  input logic [NUM_VEC*MOD_W-1:0] mod_en_flat
);
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (cpu_flag_q & ven_q));

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_v
    // R4
    evt_sets_cpu_chk: assert property (@(posedge clk) disable iff (rst)
      (|(mod_evt[v*MOD_W +: MOD_W] & mod_en_flat[v*MOD_W +: MOD_W])) |=> cpu_flag_q[v]);
    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (ack_valid && ack_vec == VEC_W'(v) && !reg_we &&
       !(|(mod_evt[v*MOD_W +: MOD_W] & mod_en_flat[v*MOD_W +: MOD_W]))) |=> !cpu_flag_q[v]);
    // R6
    set_beats_ack_chk: assert property (@(posedge clk) disable iff (rst)
      (ack_valid && ack_vec == VEC_W'(v) &&
       (|(mod_evt[v*MOD_W +: MOD_W] & mod_en_flat[v*MOD_W +: MOD_W]))) |=> cpu_flag_q[v]);
    // R3
    evt_sticks_chk: assert property (@(posedge clk) disable iff (rst)
      (|mod_evt[v*MOD_W +: MOD_W]) |=>
      ((mod_flag_flat[v*MOD_W +: MOD_W] & $past(mod_evt[v*MOD_W +: MOD_W])) ==
       $past(mod_evt[v*MOD_W +: MOD_W])));
    // R2
    mflag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!reg_we && mod_evt[v*MOD_W +: MOD_W] == '0) |=> $stable(mod_flag_flat[v*MOD_W +: MOD_W]));
    // R8
    fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_addr == '0) |=> (reg_rdata[2*v] == (v < RSV_ONES)));
  end
endmodule

bind irq_flag_agg irq_flag_agg_chk #(
  .NUM_VEC(NUM_VEC), .MOD_W(MOD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .RSV_ONES(RSV_ONES), .VEC_W(VEC_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mod_evt       (mod_evt),
  .reg_we        (reg_we),
  .reg_addr      (reg_addr),
  .reg_rdata     (reg_rdata),
  .ack_valid     (ack_valid),
  .ack_vec       (ack_vec),
  .irq           (irq),
  .cpu_flag_q    (cpu_flag_q),
  .ven_q         (ven_q),
  .mod_flag_flat (mod_flag_flat),
  .mod_en_flat   (mod_en_flat)
);

// File: tb/irq_flag_agg_bench.sv
module irq_flag_agg_bench;
  localparam int NV = 4;
  localparam int MW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NV*MW-1:0] mod_evt = '0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          ack_valid = 1'b0;
  logic [1:0]    ack_vec = '0;
  logic [NV-1:0] irq;

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  irq_flag_agg u_irq_flag_agg (
    .clk(clk), .rst(rst), .mod_evt(mod_evt), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_valid(ack_valid),
    .ack_vec(ack_vec), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk);
    reg_addr = 4'(a);
    @(negedge clk);
    chk(reg_rdata == 8'(exp), tag, int'(reg_rdata), exp);
  endtask

  task automatic pulse(input int v, input int b);
    @(negedge clk);
    mod_evt[v*MW + b] = 1'b1;
    @(negedge clk);
    mod_evt = '0;
  endtask

  task automatic ack(input int v);
    @(negedge clk);
    ack_valid = 1'b1; ack_vec = 2'(v);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic irq_chk(input int exp, input string tag);
    chk(irq == NV'(exp), tag, int'(irq), exp);
  endtask

  task automatic t_reset();
    rd_chk(0, 8'h05, "R1 cpu reg reset");
    rd_chk(1, 8'h00, "R1 vec enable reset");
    rd_chk(2, 8'h00, "R1 module flags reset");
    rd_chk(3, 8'h00, "R1 module enable reset");
    irq_chk(0, "R1 irq reset");
  endtask

  task automatic t_modflag();
    pulse(0, 7);
    rd_chk(2, 8'h80, "R2 event sets module flag");
    rd_chk(0, 8'h05, "R4 disabled event leaves cpu flag");
    wr(2, 8'hFF);
    rd_chk(2, 8'h80, "R2 write one no effect");
    wr(2, 8'h7F);
    rd_chk(2, 8'h00, "R2 write zero clears");
  endtask

  task automatic t_evt_set();
    wr(3, 8'hC0);
    wr(1, 8'h0F);
    pulse(0, 6);
    irq_chk(4'b0001, "R9 irq follows enabled flag");
    rd_chk(0, 8'h07, "R4 enabled event sets cpu flag");
    rd_chk(3, 8'hC0, "R10 module enable map");
  endtask

  task automatic t_ack();
    ack(1);
    rd_chk(0, 8'h07, "R5 other vector ack no effect");
    ack(0);
    irq_chk(0, "R5 irq drops after ack");
    rd_chk(0, 8'h05, "R5 ack clears cpu flag");
    rd_chk(2, 8'h40, "R5 ack keeps module flags");
  endtask

  task automatic t_reflag();
    pulse(0, 7);
    ack(0);
    rd_chk(0, 8'h05, "R7 flag cleared before recheck");
    wr(2, 8'h7F);
    rd_chk(0, 8'h07, "R7 clear with pending re-sets cpu");
    rd_chk(2, 8'h40, "R7 remaining module flag");
    ack(0);
    wr(2, 8'h00);
    rd_chk(0, 8'h05, "R7 last clear does not re-set");
  endtask

  task automatic t_race_mod();
    @(negedge clk);
    mod_evt[1*MW + 5] = 1'b1;
    reg_we = 1'b1; reg_addr = 4'd4; reg_wdata = 8'h00;
    @(negedge clk);
    mod_evt = '0; reg_we = 1'b0;
    rd_chk(4, 8'h20, "R3 event beats clear");
  endtask

  task automatic t_race_ack();
    wr(7, 8'h01);
    @(negedge clk);
    mod_evt[2*MW + 0] = 1'b1;
    ack_valid = 1'b1; ack_vec = 2'd2;
    @(negedge clk);
    mod_evt = '0; ack_valid = 1'b0;
    irq_chk(4'b0100, "R6 irq stays after collision");
    rd_chk(0, 8'h25, "R6 set beats ack");
  endtask

  task automatic t_sw_cpu();
    wr(0, 8'hFF);
    rd_chk(0, 8'hAF, "R8 write all ones fixed bits");
    irq_chk(4'b1111, "R9 irq all vectors");
    wr(0, 8'h00);
    rd_chk(0, 8'h05, "R8 write zeros keeps reserved ones");
  endtask

  task automatic t_ven();
    wr(0, 8'h0A);
    irq_chk(4'b0011, "R9 two vectors requesting");
    wr(1, 8'h02);
    irq_chk(4'b0010, "R9 enable write next edge");
    rd_chk(1, 8'h02, "R10 vector enable map");
    rd_chk(0, 8'h0F, "R8 pending bits 1 and 3");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_modflag();
    t_evt_set();
    t_ack();
    t_reflag();
    t_race_mod();
    t_race_ack();
    t_sw_cpu();
    t_ven();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule